// File: doc/BRIEF.md
# Serial Test Pattern Receive Synchronizer

This block sits on the receive side of a bit error tester. It takes one serial bit per clock, qualified by a receive-disable input, and checks the stream against a configured test pattern. Two pattern families are supported. In pseudorandom mode each bit is predicted from earlier bits through a two-tap exclusive-OR feedback: one tap is fixed at the pattern length and the other can be programmed. In repetitive mode each bit is predicted to equal the bit one pattern length earlier.

While hunting, the block fills its reference history with the received bits, so prediction locks onto the stream by itself. Once enough consecutive bits match, it declares lock. From then on it runs the reference on its own prediction and flags every received bit that differs from it. Lock can be dropped automatically on a burst of errors, or kept until a manual resync request. The block also reports runs of all ones and all zeros, and it captures a 32-bit snapshot of its history on request. Loopback and receive inversion choose and condition the bit that enters the checker. Counting and host access are handled elsewhere.

Top module: `rx_pattern_sync`

## Requirements
- R1: The received bit is sampled only on clock edges where `rx_dis_i` is low. If `len_i` is L, lock (`sync_o`=1) is declared on the sampled bit that completes 35+L consecutive sampled bits matching the prediction while hunting. After reset the block hunts.
- R2: When `manual_i`=0 and the block is locked, lock drops as soon as 6 or more of the last 64 sampled bits are errored. Hunting then restarts with a cleared window.
- R3: When `manual_i`=1, errors never drop lock. A rising edge on `resync_i` drops lock in either setting and restarts the hunt, even on a disabled cycle.
- R4: `err_o` pulses for one cycle for each sampled bit that differs from the prediction. It pulses only when the block was locked before that bit, and never on a resync edge.
- R5: `bit_vld_o` pulses for each sampled bit. On a disabled cycle there is no pulse, the history, run detectors, lock counters and error window stay unchanged, and `err_o` stays 0.
- R6: `all_ones_o` is set after 32 consecutive sampled 1s and cleared by a sampled 0. `all_zeros_o` is set after 32 consecutive sampled 0s and cleared by a sampled 1.
- R7: With `rx_inv_i`=1, the selected input bit is complemented before it is checked.
- R8: With `loop_en_i`=1, `tx_bit_i` replaces `rx_data_i` as the input bit.
- R9: A rising edge on `capture_i` loads the 32-bit history into `cap_word_o`. Bit 0 is the most recently shifted bit and bit k is the bit k positions older. At any other time `cap_word_o` holds its value. While hunting, the history holds the raw sampled bits.
- R10: While locked, the history shifts in the predicted bit and not the received bit. Errored bits therefore never appear in a captured word, and in repetitive mode the word is a rotation of the locked pattern.
- R11: The prediction is history bit L in repetitive mode (`prbs_mode_i`=0). In pseudorandom mode (`prbs_mode_i`=1) it is history bit L XOR history bit `tap_i`, where history bit k is the sampled bit k+1 positions back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_data_i | input | 1 | External received bit |
| rx_dis_i | input | 1 | High: do not sample this cycle |
| tx_bit_i | input | 1 | Transmitted bit, used in loopback |
| loop_en_i | input | 1 | Select tx_bit_i as input |
| rx_inv_i | input | 1 | Complement input bit |
| prbs_mode_i | input | 1 | 1 pseudorandom, 0 repetitive |
| len_i | input | 5 | Pattern length minus one (L) |
| tap_i | input | 5 | Second feedback tap index |
| manual_i | input | 1 | 1 disables automatic lock drop |
| resync_i | input | 1 | Rising edge forces a new hunt |
| capture_i | input | 1 | Rising edge captures history |
| sync_o | output | 1 | Lock status |
| err_o | output | 1 | Errored-bit pulse |
| bit_vld_o | output | 1 | Sampled-bit pulse |
| all_ones_o | output | 1 | 32 or more consecutive ones |
| all_zeros_o | output | 1 | 32 or more consecutive zeros |
| cap_word_o | output | 32 | Captured history word |

## Verification
Every output is registered. The bit sampled at an edge drives `bit_vld_o`, `err_o`, the run flags and any lock change on that edge, and a capture or resync edge also takes effect on the same edge. So each result is due exactly one clock after its stimulus is presented. The bench applies each stimulus 1 ns after a rising edge. It then advances its behavioural model by one bit and compares every output 1 ns after the next rising edge. Spot checks at scenario ends confirm lock and flag states that follow directly from the requirements.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;
  localparam int unsigned HIST_W    = 32;
  localparam int unsigned SYNC_BASE = 34;
  localparam int unsigned WIN_LEN   = 64;
  localparam int unsigned ERR_LIMIT = 6;
  localparam int unsigned RUN_LEN   = 32;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;
endpackage

// File: rtl/rx_hist_pred.sv
module rx_hist_pred #(
  parameter int unsigned HIST_W = 32,
  localparam int unsigned LEN_W = $clog2(HIST_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              shift_bit_i,
  input  logic              prbs_mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  tap_i,
  output logic [HIST_W-1:0] hist_o,
  output logic              pred_o
);
  logic [HIST_W-1:0] hist_q;

  // bit k holds the bit shifted in k+1 shifts ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], shift_bit_i};
  end

  assign pred_o = hist_q[len_i] ^ (prbs_mode_i & hist_q[tap_i]);
  assign hist_o = hist_q;
endmodule

// File: rtl/rx_err_window.sv
module rx_err_window #(
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6,
  localparam int unsigned CNT_W    = $clog2(WIN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic err_i,
  output logic over_o
);
  logic [WIN_LEN-1:0] win_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(err_i) - CNT_W'(win_q[WIN_LEN-1]);
  assign over_o  = upd_i && (cnt_nxt >= CNT_W'(ERR_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (upd_i) begin
      win_q <= {win_q[WIN_LEN-2:0], err_i};
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rx_run_det.sv
module rx_run_det #(
  parameter int unsigned RUN_LEN = 32,
  parameter bit          MATCH   = 1'b1,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic bit_i,
  output logic flag_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (vld_i) begin
      if (bit_i != MATCH)                cnt_q <= '0;
      else if (cnt_q != CNT_W'(RUN_LEN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = (cnt_q == CNT_W'(RUN_LEN));
endmodule

// File: rtl/rx_pattern_sync.sv
module rx_pattern_sync
  import rx_sync_pkg::*;
#(
  parameter int unsigned HIST_W    = rx_sync_pkg::HIST_W,
  parameter int unsigned SYNC_BASE = rx_sync_pkg::SYNC_BASE,
  parameter int unsigned WIN_LEN   = rx_sync_pkg::WIN_LEN,
  parameter int unsigned ERR_LIMIT = rx_sync_pkg::ERR_LIMIT,
  parameter int unsigned RUN_LEN   = rx_sync_pkg::RUN_LEN,
  localparam int unsigned LEN_W    = $clog2(HIST_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_data_i,
  input  logic              rx_dis_i,
  input  logic              tx_bit_i,
  input  logic              loop_en_i,
  input  logic              rx_inv_i,
  input  logic              prbs_mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  tap_i,
  input  logic              manual_i,
  input  logic              resync_i,
  input  logic              capture_i,
  output logic              sync_o,
  output logic              err_o,
  output logic              bit_vld_o,
  output logic              all_ones_o,
  output logic              all_zeros_o,
  output logic [HIST_W-1:0] cap_word_o
);
  localparam int unsigned GOOD_W = $clog2(SYNC_BASE + HIST_W + 1);

  sync_state_e       state_q, state_d;
  logic [GOOD_W-1:0] good_q, good_d, thr;
  logic              res_q, cap_q, err_q, vld_q;
  logic [HIST_W-1:0] cap_q_word, hist;
  logic              rx_bit, vld, res_edge, cap_edge, lock;
  logic              pred, mismatch, shift_bit, over, win_clr, win_upd;
  logic [1:0]        run_flag;

  assign rx_bit   = (loop_en_i ? tx_bit_i : rx_data_i) ^ rx_inv_i;
  assign vld      = ~rx_dis_i;
  assign res_edge = resync_i & ~res_q;
  assign cap_edge = capture_i & ~cap_q;
  assign lock     = (state_q == ST_LOCK);
  assign mismatch = rx_bit ^ pred;
  // locked: reference free-runs on its own prediction
  assign shift_bit = (lock && !res_edge) ? pred : rx_bit;
  assign thr       = GOOD_W'(SYNC_BASE + 1) + GOOD_W'(len_i);

  rx_hist_pred #(.HIST_W(HIST_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (vld),
    .shift_bit_i (shift_bit),
    .prbs_mode_i (prbs_mode_i),
    .len_i       (len_i),
    .tap_i       (tap_i),
    .hist_o      (hist),
    .pred_o      (pred)
  );

  assign win_upd = vld & lock & ~res_edge;
  assign win_clr = res_edge | ~lock | (over & ~manual_i);

  rx_err_window #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (win_clr),
    .upd_i  (win_upd),
    .err_i  (mismatch),
    .over_o (over)
  );

  for (genvar g = 0; g < 2; g++) begin : g_run
    rx_run_det #(.RUN_LEN(RUN_LEN), .MATCH(g[0])) u_run (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld),
      .bit_i  (rx_bit),
      .flag_o (run_flag[g])
    );
  end

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    if (res_edge) begin
      state_d = ST_HUNT;
      good_d  = '0;
    end else if (vld) begin
      if (!lock) begin
        if (mismatch) good_d = '0;
        else if (good_q + 1'b1 == thr) begin
          state_d = ST_LOCK;
          good_d  = '0;
        end else good_d = good_q + 1'b1;
      end else if (over && !manual_i) begin
        state_d = ST_HUNT;
        good_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      good_q     <= '0;
      res_q      <= 1'b0;
      cap_q      <= 1'b0;
      err_q      <= 1'b0;
      vld_q      <= 1'b0;
      cap_q_word <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
      res_q   <= resync_i;
      cap_q   <= capture_i;
      err_q   <= win_upd & mismatch;
      vld_q   <= vld;
      if (cap_edge) cap_q_word <= hist;
    end
  end

  assign sync_o      = lock;
  assign err_o       = err_q;
  assign bit_vld_o   = vld_q;
  assign all_zeros_o = run_flag[0];
  assign all_ones_o  = run_flag[1];
  assign cap_word_o  = cap_q_word;
endmodule

// File: rtl/rx_pattern_sync_chk.sv
module rx_pattern_sync_chk #(
  parameter int unsigned HIST_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_dis_i,
  input logic              manual_i,
  input logic              resync_i,
  input logic              capture_i,
  input logic              sync_o,
  input logic              err_o,
  input logic              bit_vld_o,
  input logic              all_ones_o,
  input logic              all_zeros_o,
  input logic [HIST_W-1:0] cap_word_o
);
  a_r5_dis_no_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i |=> !bit_vld_o);
  a_r5_dis_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i |=> !err_o);
  a_r4_err_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(sync_o));
  a_r4_err_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> bit_vld_o);
  a_r1_lock_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> bit_vld_o);
  a_r3_manual_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_i && sync_o && !resync_i) |=> sync_o);
  a_r6_runs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(all_ones_o && all_zeros_o));
  a_r9_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(cap_word_o));
endmodule

bind rx_pattern_sync rx_pattern_sync_chk #(.HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_dis_i    (rx_dis_i),
  .manual_i    (manual_i),
  .resync_i    (resync_i),
  .capture_i   (capture_i),
  .sync_o      (sync_o),
  .err_o       (err_o),
  .bit_vld_o   (bit_vld_o),
  .all_ones_o  (all_ones_o),
  .all_zeros_o (all_zeros_o),
  .cap_word_o  (cap_word_o)
);

// File: tb/rx_pattern_sync_test.sv
`timescale 1ns/1ps
module rx_pattern_sync_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_data = 0, rx_dis = 0, tx_bit = 0, loop_en = 0, rx_inv = 0;
  logic        prbs = 0, manual = 0, resync = 0, capture = 0;
  logic [4:0]  len = 0, tap = 0;
  logic        sync_o, err_o, vld_o, ones_o, zeros_o;
  logic [31:0] cap_o;

  int vecs = 0, fails = 0;
  string cur_req = "R1";

  // behavioural model state
  logic hq[$];
  logic wq[$];
  logic gq[$];
  int   good = 0, ones_run = 0, zeros_run = 0;
  logic m_sync = 0, m_err = 0, m_vld = 0, m_res_q = 0, m_cap_q = 0;
  logic [31:0] m_cap = 0;

  always #2.5 clk = ~clk;

  rx_pattern_sync uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_dis_i(rx_dis),
    .tx_bit_i(tx_bit), .loop_en_i(loop_en), .rx_inv_i(rx_inv),
    .prbs_mode_i(prbs), .len_i(len), .tap_i(tap), .manual_i(manual),
    .resync_i(resync), .capture_i(capture), .sync_o(sync_o), .err_o(err_o),
    .bit_vld_o(vld_o), .all_ones_o(ones_o), .all_zeros_o(zeros_o),
    .cap_word_o(cap_o)
  );

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", req, nm, act, exp);
    end
  endtask

  task automatic model_step();
    logic b, pred, mis, re, ce;
    int s;
    b  = (loop_en ? tx_bit : rx_data) ^ rx_inv;   // R7 R8
    re = resync && !m_res_q;
    ce = capture && !m_cap_q;
    m_res_q = resync;
    m_cap_q = capture;
    if (ce) for (int k = 0; k < 32; k++) m_cap[k] = hq[k];  // R9
    m_vld = !rx_dis;
    m_err = 0;
    if (re) begin
      m_sync = 0; good = 0; wq.delete();
    end
    if (!rx_dis) begin
      pred = prbs ? (hq[len] ^ hq[tap]) : hq[len];  // R11
      mis  = b != pred;
      if (re || !m_sync) begin
        hq.push_front(b);
        if (!re) begin
          if (mis) good = 0;
          else begin
            good++;
            if (good == 35 + int'(len)) begin m_sync = 1; good = 0; end  // R1
          end
        end
      end else begin
        m_err = mis;                 // R4
        hq.push_front(pred);         // R10
        wq.push_front(mis);
        if (wq.size() > 64) void'(wq.pop_back());
        s = 0;
        foreach (wq[i]) s += int'(wq[i]);
        if (!manual && s >= 6) begin m_sync = 0; good = 0; wq.delete(); end  // R2 R3
      end
      void'(hq.pop_back());
      if (b) begin zeros_run = 0; if (ones_run < 32) ones_run++; end  // R6
      else   begin ones_run = 0;  if (zeros_run < 32) zeros_run++; end
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "sync_o", 32'(sync_o), 32'(m_sync));
    chk(cur_req, "err_o", 32'(err_o), 32'(m_err));
    chk(cur_req, "bit_vld_o", 32'(vld_o), 32'(m_vld));
    chk(cur_req, "all_ones_o", 32'(ones_o), 32'(ones_run == 32));
    chk(cur_req, "all_zeros_o", 32'(zeros_o), 32'(zeros_run == 32));
    chk(cur_req, "cap_word_o", cap_o, m_cap);
  endtask

  // b is the logical bit the checker should see
  task automatic cyc(input logic b, input logic dis = 1'b0);
    logic raw;
    raw = b ^ rx_inv;
    rx_dis = dis;
    if (loop_en) begin tx_bit = raw; rx_data = ~raw; end
    else begin rx_data = raw; tx_bit = 1'($urandom); end
    @(posedge clk); #1;
    model_step();
    compare_all();
  endtask

  task automatic rep_bits(input logic [31:0] pw, input int n, input int cnt,
                          inout int ph, input int err_every = 0);
    for (int i = 0; i < cnt; i++) begin
      logic b;
      b = pw[n - 1 - (ph % n)];
      ph++;
      if (err_every != 0 && (i % err_every) == err_every - 1) b = ~b;
      cyc(b);
    end
  endtask

  task automatic prbs_bits(input int cnt, input int err_at = -1);
    for (int i = 0; i < cnt; i++) begin
      logic b;
      b = gq[len] ^ gq[tap];
      gq.push_front(b);
      void'(gq.pop_back());
      cyc((i == err_at) ? ~b : b);
    end
  endtask

  initial begin
    int ph;
    for (int k = 0; k < 32; k++) hq.push_back(1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    cur_req = "R1";
    chk("R1", "reset sync_o", 32'(sync_o), 0);
    chk("R6", "reset all_ones_o", 32'(ones_o), 0);
    chk("R9", "reset cap_word_o", cap_o, 0);

    // repetitive 8-bit pattern, lock
    cur_req = "R11"; len = 5'd7; ph = 0;
    rep_bits(32'h26, 8, 60, ph);
    chk("R1", "locked after clean run", 32'(sync_o), 1);

    // sparse errors keep lock
    cur_req = "R4";
    rep_bits(32'h26, 8, 80, ph, 25);
    chk("R2", "lock kept below limit", 32'(sync_o), 1);

    // capture while locked
    cur_req = "R10";
    capture = 1; cyc(1'b0 ^ 1'b0); capture = 0;
    rep_bits(32'h26, 8, 2, ph);
    chk("R10", "captured word period 8", 32'(cap_o[7:0]), 32'(cap_o[15:8]));

    // burst of errors drops lock
    cur_req = "R2";
    rep_bits(32'h26, 8, 30, ph, 5);
    chk("R2", "lock dropped", 32'(sync_o), 0);

    // capture while hunting, gapped relock
    cur_req = "R9";
    rep_bits(32'h26, 8, 5, ph);
    capture = 1; rep_bits(32'h26, 8, 1, ph); capture = 0;
    cur_req = "R5";
    for (int i = 0; i < 120; i++) begin
      logic b;
      b = 32'h26 >> (7 - (ph % 8));
      if (i % 3 == 1) cyc(~b, 1'b1);
      else begin ph++; cyc(b); end
    end
    chk("R5", "relock with gaps", 32'(sync_o), 1);

    // manual mode: errors never drop, resync does
    cur_req = "R3"; manual = 1;
    rep_bits(32'h26, 8, 40, ph, 2);
    chk("R3", "manual keeps lock", 32'(sync_o), 1);
    resync = 1; cyc(1'b1, 1'b1); resync = 0;
    chk("R3", "resync drops lock", 32'(sync_o), 0);
    manual = 0;

    // runs of ones and zeros
    cur_req = "R6";
    for (int i = 0; i < 40; i++) cyc(1'b1);
    chk("R6", "all ones set", 32'(ones_o), 1);
    cyc(1'b0);
    chk("R6", "all ones cleared", 32'(ones_o), 0);
    for (int i = 0; i < 40; i++) cyc(1'b0);
    chk("R6", "all zeros set", 32'(zeros_o), 1);

    // pseudorandom 7-stage with inversion and loopback
    cur_req = "R8"; prbs = 1; len = 5'd6; tap = 5'd5; rx_inv = 1; loop_en = 1;
    resync = 1; cyc(1'b0); resync = 0;
    for (int k = 0; k < 32; k++) gq.push_back(1'b1);
    prbs_bits(100);
    chk("R11", "pseudorandom lock", 32'(sync_o), 1);
    cur_req = "R7";
    prbs_bits(20, 7);
    chk("R7", "inverted stream locked", 32'(sync_o), 1);

    // full 32-bit repetitive length
    cur_req = "R11"; prbs = 0; rx_inv = 0; loop_en = 0; len = 5'd31; ph = 0;
    rep_bits(32'hF0E1_2D3C, 32, 140, ph);
    chk("R1", "32-bit pattern lock", 32'(sync_o), 1);
    capture = 1; rep_bits(32'hF0E1_2D3C, 32, 1, ph, 1); capture = 0;
    rep_bits(32'hF0E1_2D3C, 32, 1, ph);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule